// File: doc/BRIEF.md
# Serially Loaded Bank-Switching Mapper

This block sits on the write side of an 8-bit CPU bus and turns a stream of single-bit writes into cartridge bank numbers. Writes to the upper 32K window carry one payload bit each (data bit 0). Five of them fill a 5-bit staging buffer, least significant bit first. The fifth write commits the buffer to one of four internal registers: a control register, two pattern-table registers and a program register. Address bits 14:13 of that fifth write pick the register. A write with data bit 7 set empties the staging buffer and forces the program layout that pins the upper 16K window to the last bank.

From those registers the block produces these outputs:
- the 16K program bank numbers for the lower and upper halves of the window;
- two 4K pattern-table bank numbers;
- a 2-bit nametable mirroring code;
- an enable and a bank bit for the 8K work-RAM window.

The block also steers the CPU read data for that work-RAM window: it passes the RAM's byte through, or hands back the open-bus byte while the RAM is disabled. A CPU cycle count input lets the block drop any write that lands within two cycles of the previous accepted reset write. This filters out the second write of a read-modify-write instruction.

The ROM and RAM arrays are not part of this block.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the control register holds 0x1F and the other registers hold 0, with the buffer empty. The outputs are therefore: program banks 0 (lower) and 15 (upper), pattern banks 0 and 0, mirroring code 3, work RAM enabled, and work-RAM bank 0.
- R2: A write whose data bit 7 is clear shifts data bit 0 into the buffer, least significant bit first. On the fifth such write, the buffer goes to the register picked by the write's address bits 14:13 (wr_sel): 0 = control, 1 = pattern register A, 2 = pattern register B, 3 = program register. The buffer and count then clear. Outputs show the new value right after the clock edge that samples the fifth write, and do not change after only four writes.
- R3: An accepted write with data bit 7 set clears the buffer and count, and ORs 0x0C into the control register. The mirroring and pattern-mode bits are left alone.
- R4: A write whose cyc_cnt is less than 2 after the cyc_cnt of the last accepted reset write is ignored entirely. A write exactly 2 cycles later is accepted.
- R5: With control bits 3:2 = 3, the lower window gets the program register's bits 3:0 and the upper window gets bank 15.
- R6: With control bits 3:2 = 2, the lower window gets bank 0 and the upper window gets the program register's bits 3:0.
- R7: With control bits 3:2 = 0 or 1, the lower window gets program bits 3:0 with bit 0 cleared, and the upper window gets that value plus 1.
- R8: Bit 4 of pattern register A becomes bit 4 of both program bank numbers in every mode, the fixed banks included.
- R9: With control bit 4 set, the pattern banks are register A and register B as 4K bank numbers. With it clear, an 8K bank of A>>1 is used, given as the 4K pair {A[4:1],0} and {A[4:1],1}.
- R10: Control bits 1:0 drive mirror_mode directly: 0 = single-screen A, 1 = single-screen B, 2 = vertical, 3 = horizontal.
- R11: Work RAM is enabled only while program register bit 4 is clear, unless WRAM_ALWAYS is set. While it is disabled, cpu_rdata returns open_bus; otherwise it returns ram_rdata.
- R12: With WRAM_KB = 16, wram_bank is pattern register A bit 4 when control bit 4 is set, and A bit 3 otherwise. With 8K it is 0.
- R13: The bank outputs are masked to the configured sizes by keeping only log2(PRG_KB/16) and log2(CHR_KB/4) low bits. The maximums are 512K of program and 128K of pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_stb | input | 1 | One-cycle strobe for a write into 0x8000-0xFFFF |
| wr_sel | input | 2 | CPU address bits 14:13 of the write |
| wr_data | input | 8 | CPU write data |
| cyc_cnt | input | CYC_W | Free-running CPU cycle count |
| ram_rdata | input | 8 | Byte read from work RAM |
| open_bus | input | 8 | Last value seen on the CPU data bus |
| prg_lo_bank | output | PRG_W | 16K bank for 0x8000-0xBFFF |
| prg_hi_bank | output | PRG_W | 16K bank for 0xC000-0xFFFF |
| chr_lo_bank | output | CHR_W | 4K bank for pattern table 0 |
| chr_hi_bank | output | CHR_W | 4K bank for pattern table 1 |
| mirror_mode | output | 2 | Nametable mirroring code |
| wram_en | output | 1 | Work RAM access enable |
| wram_bank | output | 1 | 8K work-RAM bank select |
| cpu_rdata | output | 8 | Read data for the work-RAM window |

## Verification
The hardest case to reach is the write-after-reset filter, because it depends on how far apart two writes fall in CPU cycles rather than in clock edges. The bench drives cyc_cnt directly. It places a serial write one cycle after a reset write, then starts a full five-write load exactly two cycles after the reset. If the dropped bit had been taken, the committed value would come out shifted and the program bank output would show the wrong number. A second instance with reduced sizes and the RAM bypass checks masking and the always-enabled RAM against the same stimulus.

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper #(
  parameter int PRG_KB      = 512,
  parameter int CHR_KB      = 128,
  parameter int WRAM_KB     = 16,
  parameter bit WRAM_ALWAYS = 1'b0,
  parameter int CYC_W       = 16,
  localparam int PRG_W = $clog2(PRG_KB / 16),
  localparam int CHR_W = $clog2(CHR_KB / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [CYC_W-1:0] cyc_cnt,
  input  logic [7:0]       ram_rdata,
  input  logic [7:0]       open_bus,
  output logic [PRG_W-1:0] prg_lo_bank,
  output logic [PRG_W-1:0] prg_hi_bank,
  output logic [CHR_W-1:0] chr_lo_bank,
  output logic [CHR_W-1:0] chr_hi_bank,
  output logic [1:0]       mirror_mode,
  output logic             wram_en,
  output logic             wram_bank,
  output logic [7:0]       cpu_rdata
);

  logic [4:0]       ctrl_q, chra_q, chrb_q, prg_q, buf_q;
  logic [2:0]       cnt_q;
  logic [CYC_W-1:0] rst_cyc_q;
  logic             rst_seen_q;

  logic [CYC_W-1:0] since_rst;
  logic             accept, take_rst, take_bit, commit;
  logic [4:0]       full;

  assign since_rst = cyc_cnt - rst_cyc_q;
  assign accept    = wr_stb && !(rst_seen_q && since_rst < CYC_W'(2));
  assign take_rst  = accept && wr_data[7];
  assign take_bit  = accept && !wr_data[7];
  assign commit    = take_bit && cnt_q == 3'd4;
  assign full      = {wr_data[0], buf_q[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= 5'h1F;
      chra_q     <= '0;
      chrb_q     <= '0;
      prg_q      <= '0;
      buf_q      <= '0;
      cnt_q      <= '0;
      rst_cyc_q  <= '0;
      rst_seen_q <= 1'b0;
    end else if (take_rst) begin
      buf_q      <= '0;
      cnt_q      <= '0;
      ctrl_q     <= ctrl_q | 5'h0C;
      rst_cyc_q  <= cyc_cnt;
      rst_seen_q <= 1'b1;
    end else if (commit) begin
      case (wr_sel)
        2'd0:    ctrl_q <= full;
        2'd1:    chra_q <= full;
        2'd2:    chrb_q <= full;
        default: prg_q  <= full;
      endcase
      buf_q <= '0;
      cnt_q <= '0;
    end else if (take_bit) begin
      buf_q[cnt_q[1:0]] <= wr_data[0];
      cnt_q <= cnt_q + 3'd1;
    end
  end

  logic [4:0] prg_lo_raw, prg_hi_raw, chr_lo_raw, chr_hi_raw;
  logic       outer;

  assign outer = chra_q[4];

  always_comb begin
    case (ctrl_q[3:2])
      2'b11: begin
        prg_lo_raw = {outer, prg_q[3:0]};
        prg_hi_raw = {outer, 4'hF};
      end
      2'b10: begin
        prg_lo_raw = {outer, 4'h0};
        prg_hi_raw = {outer, prg_q[3:0]};
      end
      default: begin
        prg_lo_raw = {outer, prg_q[3:1], 1'b0};
        prg_hi_raw = {outer, prg_q[3:1], 1'b1};
      end
    endcase
  end

  assign chr_lo_raw = ctrl_q[4] ? chra_q : {chra_q[4:1], 1'b0};
  assign chr_hi_raw = ctrl_q[4] ? chrb_q : {chra_q[4:1], 1'b1};

  assign prg_lo_bank = prg_lo_raw[PRG_W-1:0];
  assign prg_hi_bank = prg_hi_raw[PRG_W-1:0];
  assign chr_lo_bank = chr_lo_raw[CHR_W-1:0];
  assign chr_hi_bank = chr_hi_raw[CHR_W-1:0];
  assign mirror_mode = ctrl_q[1:0];

  assign wram_en   = WRAM_ALWAYS ? 1'b1 : !prg_q[4];
  assign wram_bank = (WRAM_KB > 8) ? (ctrl_q[4] ? chra_q[4] : chra_q[3]) : 1'b0;
  assign cpu_rdata = wram_en ? ram_rdata : open_bus;

  assert_five_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && cnt_q == 3'd4) |=> cnt_q == 3'd0);

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && cnt_q < 3'd4) |=> cnt_q == $past(cnt_q) + 3'd1);

  assert_reset_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_rst |=> (ctrl_q[3:2] == 2'b11 && cnt_q == 3'd0 && $stable(mirror_mode)));

  assert_drop_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !accept) |=> ($stable(cnt_q) && $stable(ctrl_q) && $stable(prg_q)
                             && $stable(chra_q) && $stable(chrb_q)));

  assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[3] |-> prg_hi_bank == (prg_lo_bank | PRG_W'(1)));

  assert_chr8k_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> chr_hi_bank == (chr_lo_bank | CHR_W'(1)));

  assert_open_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRAM_ALWAYS && prg_q[4]) |-> cpu_rdata == open_bus);

endmodule

// File: tb/serial_bank_mapper_test.sv
module serial_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cyc_cnt = '0;
  logic [7:0]  ram_rdata = 8'hA5;
  logic [7:0]  open_bus = 8'h3C;

  logic [4:0] plo, phi, clo, chi;
  logic [1:0] mir;
  logic       wen, wbk;
  logic [7:0] rd;
  logic [2:0] s_plo, s_phi;
  logic [3:0] s_clo, s_chi;
  logic [1:0] s_mir;
  logic       s_wen, s_wbk;
  logic [7:0] s_rd;

  int checks = 0;
  int fails = 0;
  int cyc_now = 10;

  always #10 clk = ~clk;

  serial_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .cyc_cnt(cyc_cnt), .ram_rdata(ram_rdata), .open_bus(open_bus),
    .prg_lo_bank(plo), .prg_hi_bank(phi), .chr_lo_bank(clo), .chr_hi_bank(chi),
    .mirror_mode(mir), .wram_en(wen), .wram_bank(wbk), .cpu_rdata(rd));

  serial_bank_mapper #(.PRG_KB(128), .CHR_KB(64), .WRAM_KB(8), .WRAM_ALWAYS(1'b1)) uut_small (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .cyc_cnt(cyc_cnt), .ram_rdata(ram_rdata), .open_bus(open_bus),
    .prg_lo_bank(s_plo), .prg_hi_bank(s_phi), .chr_lo_bank(s_clo), .chr_hi_bank(s_chi),
    .mirror_mode(s_mir), .wram_en(s_wen), .wram_bank(s_wbk), .cpu_rdata(s_rd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input int c);
    wr_sel = s; wr_data = d; cyc_cnt = 16'(c); wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic load(input logic [1:0] s, input logic [4:0] v);
    for (int i = 0; i < 5; i++) begin
      wr(s, {7'b0, v[i]}, cyc_now);
      cyc_now += 3;
    end
  endtask

  task automatic t_reset_state;
    chk("R1 prg lo", plo, 0);
    chk("R1 prg hi", phi, 15);
    chk("R1 chr lo", clo, 0);
    chk("R1 chr hi", chi, 0);
    chk("R1 mirror", mir, 3);
    chk("R1 wram_en", wen, 1);
    chk("R1 wram_bank", wbk, 0);
    chk("R1 rdata", rd, 8'hA5);
    chk("R13 small hi masked", s_phi, 7);
  endtask

  task automatic t_serial_load;
    logic [4:0] v = 5'h12;
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, {7'b0, v[i]}, cyc_now);
      cyc_now += 3;
    end
    chk("R2 no change after four writes", mir, 3);
    wr(2'd0, {7'b0, v[4]}, cyc_now);
    cyc_now += 3;
    chk("R2 R10 vertical after fifth write", mir, 2);
    chk("R7 mode0 lo", plo, 0);
    chk("R7 mode0 hi", phi, 1);
    load(2'd3, 5'd5);
    chk("R7 mode0 lo even", plo, 4);
    chk("R7 mode0 hi plus one", phi, 5);
    load(2'd1, 5'd7);
    load(2'd2, 5'd9);
    chk("R9 4K lo", clo, 7);
    chk("R9 4K hi", chi, 9);
    chk("R13 small chr lo", s_clo, 7);
  endtask

  task automatic t_modes;
    load(2'd0, 5'h0C);
    chk("R10 single A", mir, 0);
    chk("R5 fixed-last lo", plo, 5);
    chk("R5 fixed-last hi", phi, 15);
    chk("R9 8K lo", clo, 6);
    chk("R9 8K hi", chi, 7);
    load(2'd0, 5'h09);
    chk("R10 single B", mir, 1);
    chk("R6 fixed-first lo", plo, 0);
    chk("R6 fixed-first hi", phi, 5);
  endtask

  task automatic t_outer;
    load(2'd1, 5'h17);
    chk("R8 mode2 lo", plo, 16);
    chk("R8 mode2 hi", phi, 21);
    load(2'd0, 5'h0C);
    chk("R8 mode3 lo", plo, 21);
    chk("R8 mode3 hi", phi, 31);
    chk("R9 8K lo outer", clo, 22);
    chk("R12 bank from bit3", wbk, 0);
    load(2'd0, 5'h1F);
    chk("R12 bank from bit4", wbk, 1);
    chk("R9 4K lo again", clo, 23);
    chk("R13 small prg lo", s_plo, 5);
    chk("R13 small chr lo", s_clo, 7);
    chk("R12 small bank", s_wbk, 0);
  endtask

  task automatic t_reset_write;
    load(2'd0, 5'h09);
    chk("R6 before reset", phi, 21);
    wr(2'd0, 8'h01, cyc_now); cyc_now += 3;
    wr(2'd0, 8'h00, cyc_now); cyc_now += 3;
    wr(2'd3, 8'h80, cyc_now); cyc_now += 3;
    chk("R3 mode forced lo", plo, 21);
    chk("R3 mode forced hi", phi, 31);
    chk("R3 mirror kept", mir, 1);
    load(2'd3, 5'd3);
    chk("R3 buffer cleared", plo, 19);
  endtask

  task automatic t_filter;
    int c = cyc_now;
    wr(2'd3, 8'h80, c);
    wr(2'd3, 8'h01, c + 1);
    cyc_now = c + 2;
    load(2'd3, 5'd6);
    chk("R4 close write dropped", plo, 22);
    chk("R4 hi", phi, 31);
  endtask

  task automatic t_wram;
    load(2'd3, 5'h16);
    chk("R11 disabled", wen, 0);
    chk("R11 open bus", rd, 8'h3C);
    chk("R11 bypass enabled", s_wen, 1);
    chk("R11 bypass data", s_rd, 8'hA5);
    load(2'd3, 5'h06);
    chk("R11 re-enabled", wen, 1);
    chk("R11 ram data", rd, 8'hA5);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_serial_load();
    t_modes();
    t_outer();
    t_reset_write();
    t_filter();
    t_wram();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule